// File: doc/BRIEF.md
# Scratchpad Write and Authorized Copy Controller

This block sits behind a byte-level serial slave front end and in front of a paged byte RAM. It runs three memory commands against a 32-byte scratchpad. The first byte received after a bus reset selects the command. A write loads a target address and then fills the scratchpad. A read returns the address registers, the status byte and the buffered data. A copy moves the buffered bytes into RAM, but only after the master has echoed the address registers and status byte back exactly.

The status byte packs the ending offset (the last whole byte written) together with a flag for a truncated final byte and a flag that records an accepted copy. A write that fills the last scratchpad location answers with an inverted CRC16, so the master can confirm the transfer without reading it back. When a copy finishes, a page that owns a write-cycle counter receives one increment strobe. Bus resets that arrive while a copy is running are ignored.

Top module: `spad_copy_ctrl`

## Requirements
- R1: After `rst_n` is released, `tx_byte` is FFh, `ram_we` and `page_inc` are low, and a read command returns 00h, 00h, 00h as its three header bytes.
- R2: Write command 0Fh takes TA1 and then TA2. Data bytes are stored from scratchpad offset TA1[4:0] upward, one location per byte.
- R3: The status byte is {AA, 0, PF, E[4:0]}. E is the offset of the last whole data byte stored, and bit 6 always reads 0.
- R4: A `rx_partial` strobe during the data phase of a write discards the incomplete byte and sets PF (bit 5), leaving E unchanged. Later bytes are ignored until a bus reset.
- R5: Receiving command 0Fh clears PF and AA.
- R6: Target-address bits at and above log2(PAGES*32) are stored as zero. With 16 pages, TA2 = FEh reads back as 00h.
- R7: Read command AAh sends TA1, TA2 and the status byte, then scratchpad bytes from offset TA1[4:0] through 1Fh, then FFh for every further byte taken.
- R8: Copy command 5Ah compares the next three bytes with TA1, TA2 and the status byte, in that order. On a full match AA (bit 7) is set and scratchpad offsets TA1[4:0] through E are written to RAM at the address {TA[AW-1:5], offset}, one byte per cycle.
- R9: Any mismatching authorization byte ends the copy command. RAM is not written, AA is unchanged, and later bytes are ignored, with `tx_byte` reading FFh until a bus reset.
- R10: A bus reset during the RAM write sequence does not stop it. After the last write, `tx_byte` reads AAh (alternating bits) until a bus reset.
- R11: When a write stores a byte at offset 1Fh, the next two bytes taken are the low byte and then the high byte of the inverted CRC16 over the command byte, TA1, TA2 and the data. The CRC uses polynomial x16+x15+x2+1, starts at zero and takes bits LSB first. FFh follows, and further received bytes are ignored.
- R12: A completed copy raises `page_inc[p]` for exactly one cycle, together with the last RAM write, only when bit p of `WCC_MASK` is set. The default mask covers pages 12 and 13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rst | input | 1 | One-cycle strobe: reset pulse seen on the serial bus |
| rx_valid | input | 1 | One-cycle strobe: a whole received byte is on `rx_byte` |
| rx_byte | input | 8 | Received byte |
| rx_partial | input | 1 | One-cycle strobe: reception stopped partway through a byte |
| tx_take | input | 1 | One-cycle strobe: the current `tx_byte` has been sent |
| tx_byte | output | 8 | Byte to transmit next |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | AW | RAM byte address |
| ram_wdata | output | 8 | RAM write data |
| page_inc | output | PAGES | One-hot write-cycle counter increment per page |

## Verification
A wrong offset register shows up on `tx_byte` at the next data byte of a read command, or on the RAM address within one cycle of the copy starting. A corrupted flag or ending offset appears as the third byte of the next read header, and it also makes the master's own echo fail, so the copy is refused. A CRC fault shows in the two bytes taken after the 32nd data byte. A wrong copy range or a missed counter strobe is visible on the RAM port within 32 cycles of the final authorization byte.

// File: rtl/spc_pkg.sv
package spc_pkg;

    localparam int SP_BYTES = 32;
    localparam int OFFW     = $clog2(SP_BYTES);

    localparam logic [7:0] CMD_WRITE = 8'h0F;
    localparam logic [7:0] CMD_READ  = 8'hAA;
    localparam logic [7:0] CMD_COPY  = 8'h5A;
    localparam logic [7:0] DONE_PAT  = 8'hAA;
    localparam logic [15:0] CRC_POLY_R = 16'hA001;

    typedef enum logic [3:0] {
        S_CMD, S_WTA1, S_WTA2, S_WDAT, S_WCRC,
        S_RHDR, S_RDAT, S_CTA1, S_CTA2, S_CES,
        S_COPY, S_CDONE, S_HOLD
    } spc_state_e;

    function automatic logic [15:0] crc16_byte(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r;
        logic        fb;
        r = c;
        for (int k = 0; k < 8; k++) begin
            fb = r[0] ^ b[k];
            r  = r >> 1;
            if (fb) r = r ^ CRC_POLY_R;
        end
        return r;
    endfunction

endpackage

// File: rtl/spc_store.sv
module spc_store #(
    parameter int DEPTH = 32,
    parameter int W     = 8,
    localparam int AW_L = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [AW_L-1:0] waddr,
    input  logic [W-1:0]    wdata,
    input  logic [AW_L-1:0] raddr,
    output logic [W-1:0]    rdata
);

    logic [W-1:0] mem_q [DEPTH];
    logic [W-1:0] mem_d [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (we) mem_d[waddr] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
        end
    end

    assign rdata = mem_q[raddr];

    // R2: a store never uses an undefined location
    p_wr_addr_known_r2: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> !$isunknown(waddr));

endmodule

// File: rtl/spc_crc16.sv
module spc_crc16 (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [15:0] crc
);
    import spc_pkg::*;

    logic [15:0] crc_q, crc_d, base;

    always_comb begin
        base  = clr ? 16'h0000 : crc_q;
        crc_d = en ? crc16_byte(base, din) : base;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= '0;
        else        crc_q <= crc_d;
    end

    assign crc = crc_q;

    // R11: the checksum only moves when a byte is fed or it is cleared
    p_crc_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> $stable(crc_q));

endmodule

// File: rtl/spc_page_strobe.sv
module spc_page_strobe #(
    parameter int PAGES = 16,
    parameter logic [PAGES-1:0] MASK = 16'h3000,
    localparam int PGW = $clog2(PAGES)
) (
    input  logic             fire,
    input  logic [PGW-1:0]   page,
    output logic [PAGES-1:0] inc
);

    for (genvar g = 0; g < PAGES; g++) begin : g_pg
        if (MASK[g]) begin : g_cnt
            assign inc[g] = fire && (page == PGW'(g));
        end else begin : g_none
            assign inc[g] = 1'b0;
        end
    end

endmodule

// File: rtl/spad_copy_ctrl.sv
module spad_copy_ctrl #(
    parameter int PAGES = 16,
    parameter logic [PAGES-1:0] WCC_MASK = 16'h3000,
    localparam int OFFW = spc_pkg::OFFW,
    localparam int AW   = $clog2(PAGES * spc_pkg::SP_BYTES),
    localparam int PGW  = AW - OFFW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_rst,
    input  logic             rx_valid,
    input  logic [7:0]       rx_byte,
    input  logic             rx_partial,
    input  logic             tx_take,
    output logic [7:0]       tx_byte,
    output logic             ram_we,
    output logic [AW-1:0]    ram_addr,
    output logic [7:0]       ram_wdata,
    output logic [PAGES-1:0] page_inc
);
    import spc_pkg::*;

    localparam logic [15:0] TA_MASK = 16'((32'd1 << AW) - 1);
    localparam logic [OFFW-1:0] OFF_LAST = '1;

    typedef struct packed {
        spc_state_e    st;
        logic [15:0]   ta;
        logic [OFFW-1:0] eoff;
        logic          pf;
        logic          aa;
        logic [OFFW-1:0] off;
        logic [1:0]    hcnt;
        logic          rdone;
    } ctl_t;

    ctl_t q, n;

    logic        sp_we;
    logic [7:0]  sp_rdata;
    logic        crc_clr, crc_en;
    logic [15:0] crc;
    logic        copy_fire;
    logic [7:0]  es_byte;

    assign es_byte = {q.aa, 1'b0, q.pf, q.eoff};

    spc_store #(.DEPTH(SP_BYTES), .W(8)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (sp_we),
        .waddr (q.off),
        .wdata (rx_byte),
        .raddr (q.off),
        .rdata (sp_rdata)
    );

    spc_crc16 u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (crc_clr),
        .en    (crc_en),
        .din   (rx_byte),
        .crc   (crc)
    );

    spc_page_strobe #(.PAGES(PAGES), .MASK(WCC_MASK)) u_strobe (
        .fire (copy_fire),
        .page (q.ta[AW-1:OFFW]),
        .inc  (page_inc)
    );

    always_comb begin
        n         = q;
        sp_we     = 1'b0;
        crc_clr   = 1'b0;
        crc_en    = 1'b0;
        ram_we    = 1'b0;
        copy_fire = 1'b0;
        if (bus_rst && q.st != S_COPY) begin
            n.st    = S_CMD;
            n.hcnt  = '0;
            n.rdone = 1'b0;
        end else begin
            case (q.st)
                S_CMD: if (rx_valid) begin
                    case (rx_byte)
                        CMD_WRITE: begin
                            n.st    = S_WTA1;
                            n.pf    = 1'b0;
                            n.aa    = 1'b0;
                            crc_clr = 1'b1;
                            crc_en  = 1'b1;
                        end
                        CMD_READ: begin
                            n.st    = S_RHDR;
                            n.hcnt  = '0;
                            n.off   = q.ta[OFFW-1:0];
                            n.rdone = 1'b0;
                        end
                        CMD_COPY: n.st = S_CTA1;
                        default:  n.st = S_HOLD;
                    endcase
                end
                S_WTA1: if (rx_valid) begin
                    n.ta[7:0] = rx_byte & TA_MASK[7:0];
                    n.off     = rx_byte[OFFW-1:0];
                    crc_en    = 1'b1;
                    n.st      = S_WTA2;
                end
                S_WTA2: if (rx_valid) begin
                    n.ta[15:8] = rx_byte & TA_MASK[15:8];
                    crc_en     = 1'b1;
                    n.st       = S_WDAT;
                end
                S_WDAT: begin
                    if (rx_valid) begin
                        sp_we  = 1'b1;
                        crc_en = 1'b1;
                        n.eoff = q.off;
                        if (q.off == OFF_LAST) begin
                            n.st   = S_WCRC;
                            n.hcnt = '0;
                        end else begin
                            n.off = q.off + 1'b1;
                        end
                    end else if (rx_partial) begin
                        n.pf = 1'b1;
                        n.st = S_HOLD;
                    end
                end
                S_WCRC: if (tx_take && q.hcnt != 2'd2) n.hcnt = q.hcnt + 2'd1;
                S_RHDR: if (tx_take) begin
                    if (q.hcnt == 2'd2) n.st = S_RDAT;
                    else                n.hcnt = q.hcnt + 2'd1;
                end
                S_RDAT: if (tx_take && !q.rdone) begin
                    if (q.off == OFF_LAST) n.rdone = 1'b1;
                    else                   n.off   = q.off + 1'b1;
                end
                S_CTA1: if (rx_valid) n.st = (rx_byte == q.ta[7:0])  ? S_CTA2 : S_HOLD;
                S_CTA2: if (rx_valid) n.st = (rx_byte == q.ta[15:8]) ? S_CES  : S_HOLD;
                S_CES: if (rx_valid) begin
                    if (rx_byte == es_byte) begin
                        n.aa  = 1'b1;
                        n.off = q.ta[OFFW-1:0];
                        n.st  = S_COPY;
                    end else begin
                        n.st = S_HOLD;
                    end
                end
                S_COPY: begin
                    ram_we = 1'b1;
                    if (q.off == q.eoff) begin
                        copy_fire = 1'b1;
                        n.st      = S_CDONE;
                    end else begin
                        n.off = q.off + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: S_CMD, default: '0};
        end else begin
            q <= n;
        end
    end

    assign ram_addr  = {q.ta[AW-1:OFFW], q.off};
    assign ram_wdata = sp_rdata;

    always_comb begin
        case (q.st)
            S_WCRC: case (q.hcnt)
                2'd0:    tx_byte = ~crc[7:0];
                2'd1:    tx_byte = ~crc[15:8];
                default: tx_byte = 8'hFF;
            endcase
            S_RHDR: case (q.hcnt)
                2'd0:    tx_byte = q.ta[7:0];
                2'd1:    tx_byte = q.ta[15:8];
                default: tx_byte = es_byte;
            endcase
            S_RDAT:  tx_byte = q.rdone ? 8'hFF : sp_rdata;
            S_CDONE: tx_byte = DONE_PAT;
            default: tx_byte = 8'hFF;
        endcase
    end

    // R8: RAM is only written once authorization has been accepted
    p_write_needs_aa_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> q.aa);

    // R10: a bus reset cannot abort the RAM write sequence
    p_copy_ignores_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_COPY && bus_rst) |=> (q.st == S_COPY || q.st == S_CDONE));

    // R12: counter strobe only on the final byte of a copy
    p_inc_on_last_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (|page_inc) |-> (ram_we && ram_addr[OFFW-1:0] == q.eoff));

    // R12: never more than one page strobed
    p_inc_onehot_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(page_inc));

    // R5: a write command leaves both flags clear
    p_write_clears_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_CMD && !bus_rst && rx_valid && rx_byte == CMD_WRITE) |=> (!q.aa && !q.pf));

    // R9: a refused authorization leaves AA as it was
    p_refuse_keeps_aa_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_CES && !bus_rst && rx_valid && rx_byte != es_byte) |=> $stable(q.aa));

endmodule

// File: tb/sim_spad_copy_ctrl.sv
`timescale 1ns/1ps
module sim_spad_copy_ctrl;

    localparam int MEMB = 512;
    localparam int NV   = 52;
    // bits 9:8: 0 bus reset, 1 send byte, 2 take and expect byte, 3 partial strobe
    localparam logic [9:0] VEC [NV] = '{
        10'h000, 10'h10F, 10'h13A, 10'h100, 10'h111, 10'h122, 10'h000, 10'h1AA,
        10'h23A, 10'h200, 10'h21B, 10'h211, 10'h222, 10'h200, 10'h200, 10'h200,
        10'h200, 10'h2FF, 10'h000, 10'h10F, 10'h13A, 10'h100, 10'h15C, 10'h300,
        10'h000, 10'h1AA, 10'h23A, 10'h200, 10'h23A, 10'h25C, 10'h000, 10'h10F,
        10'h145, 10'h1FE, 10'h177, 10'h000, 10'h1AA, 10'h245, 10'h200, 10'h205,
        10'h277, 10'h000, 10'h15A, 10'h145, 10'h1FE, 10'h105, 10'h2FF, 10'h000,
        10'h1AA, 10'h245, 10'h200, 10'h205
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_rst = 1'b0, rx_valid = 1'b0, rx_partial = 1'b0, tx_take = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic [7:0]  tx_byte;
    logic        ram_we;
    logic [8:0]  ram_addr;
    logic [7:0]  ram_wdata;
    logic [15:0] page_inc;

    always #2 clk = ~clk;

    spad_copy_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .rx_partial(rx_partial), .tx_take(tx_take),
        .tx_byte(tx_byte), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .page_inc(page_inc)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;
    int wr_cnt = 0, inc12 = 0, inc_other = 0;
    logic [7:0] ram_model [MEMB];

    always @(posedge clk) begin
        if (ram_we) begin
            ram_model[ram_addr] <= ram_wdata;
            wr_cnt <= wr_cnt + 1;
        end
        if (page_inc[12]) inc12 <= inc12 + 1;
        if ((page_inc & ~16'h1000) != 16'h0) inc_other <= inc_other + 1;
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk); rx_valid = 1'b1; rx_byte = b;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic brst();
        @(negedge clk); bus_rst = 1'b1;
        @(negedge clk); bus_rst = 1'b0;
    endtask

    task automatic part();
        @(negedge clk); rx_partial = 1'b1;
        @(negedge clk); rx_partial = 1'b0;
    endtask

    task automatic take(input logic [7:0] exp, input string tag);
        @(negedge clk);
        chk(tag, tx_byte, exp);
        tx_take = 1'b1;
        @(negedge clk); tx_take = 1'b0;
    endtask

    function automatic string vtag(input int i);
        if (i == 10)           return "R3 status byte";
        if (i == 11 || i == 12) return "R2 stored data";
        if (i <= 17)           return "R7 read sequence";
        if (i <= 29)           return "R4 partial byte";
        if (i <= 40)           return "R6 address masking";
        return "R9 refused copy";
    endfunction

    function automatic logic [15:0] crc_ref(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r = c;
        logic [7:0]  d = b;
        repeat (8) begin
            if ((r[0] ^ d[0]) == 1'b1) r = (r >> 1) ^ 16'hA001;
            else                       r = r >> 1;
            d = d >> 1;
        end
        return r;
    endfunction

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog R1: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [15:0] crc;
        logic [7:0]  dat [32];
        int base_wr;
        int bad_bytes;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 tx idle", tx_byte, 8'hFF);
        chk("R1 ram_we", ram_we, 0);
        chk("R1 page_inc", page_inc, 0);
        send(8'hAA);
        take(8'h00, "R1 TA1");
        take(8'h00, "R1 TA2");
        take(8'h00, "R1 status");

        for (int i = 0; i < NV; i++) begin
            case (VEC[i][9:8])
                2'd0: brst();
                2'd1: send(VEC[i][7:0]);
                2'd2: take(VEC[i][7:0], vtag(i));
                default: part();
            endcase
        end
        chk("R9 no RAM write on mismatch", wr_cnt, 0);

        // R8/R10: accepted copy of one byte, bus reset during the write
        brst();
        send(8'h5A); send(8'h45); send(8'h00);
        @(negedge clk); rx_valid = 1'b1; rx_byte = 8'h05;
        @(negedge clk); rx_valid = 1'b0; bus_rst = 1'b1;
        @(negedge clk); bus_rst = 1'b0;
        chk("R10 done pattern", tx_byte, 8'hAA);
        chk("R8 RAM write count", wr_cnt, 1);
        chk("R8 RAM data at 045h", ram_model[9'h045], 8'h77);
        chk("R12 no strobe page 2", inc12 + inc_other, 0);
        take(8'hAA, "R10 pattern repeats");
        chk("R10 pattern held", tx_byte, 8'hAA);
        brst();
        send(8'hAA);
        take(8'h45, "R8 TA1");
        take(8'h00, "R8 TA2");
        take(8'h85, "R8 AA set in status");

        // R5: write command clears AA
        brst();
        send(8'h0F); send(8'h45); send(8'h00);
        brst();
        send(8'hAA);
        take(8'h45, "R5 TA1");
        take(8'h00, "R5 TA2");
        take(8'h05, "R5 flags cleared");

        // R11/R12: full page into page 12, CRC, copy with reset mid-way
        brst();
        crc = 16'h0000;
        send(8'h0F); crc = crc_ref(crc, 8'h0F);
        send(8'h80); crc = crc_ref(crc, 8'h80);
        send(8'h01); crc = crc_ref(crc, 8'h01);
        for (int i = 0; i < 32; i++) begin
            dat[i] = 8'(i * 7 + 3);
            send(dat[i]);
            crc = crc_ref(crc, dat[i]);
        end
        send(8'h99);
        take(~crc[7:0], "R11 CRC low");
        take(~crc[15:8], "R11 CRC high");
        take(8'hFF, "R11 ones after CRC");
        brst();
        base_wr = wr_cnt;
        send(8'h5A); send(8'h80); send(8'h01); send(8'h1F);
        repeat (3) @(negedge clk);
        bus_rst = 1'b1;
        @(negedge clk); bus_rst = 1'b0;
        repeat (40) @(negedge clk);
        chk("R10 copy completes through reset", wr_cnt - base_wr, 32);
        bad_bytes = 0;
        for (int i = 0; i < 32; i++) begin
            if (ram_model[9'h180 + 9'(i)] != dat[i]) bad_bytes++;
        end
        chk("R8 page 12 contents", bad_bytes, 0);
        chk("R12 page 12 strobe count", inc12, 1);
        chk("R12 no other strobe", inc_other, 0);
        chk("R10 pattern after copy", tx_byte, 8'hAA);
        brst();
        @(negedge clk);
        chk("R10 reset ends pattern", tx_byte, 8'hFF);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule